// File: doc/BRIEF.md
# Sleep-Capable Byte-Wide Static Memory Model

This block is a synthesizable, clock-sampled stand-in for an asynchronous byte-wide static memory. Its pins are active low: chip select, write enable, output enable and a sleep input. A fast internal clock registers the pins. The sampled values are then resolved into one of five modes: sleep, deselected, read, read standby and write.

Sleep takes priority over every other control. A write happens over a window, not on a single strobe. The window is open while sleep is high and both chip select and write enable are low. Any of these three signals can open or close the window. The address and byte sampled on the last clock inside the window are stored when the window closes.

The tristate data bus is split into three parts: a data-in port, a data-out port and a drive-enable. Drive-enable is high only in read mode. The address width is a parameter: the full-size array would use 19 bits, and a smaller default keeps simulation light.

Top module: `sramSleepModel`

## Requirements
- R1: While sleep is sampled low, drive-enable is low whatever chip select, write enable and output enable are, and no write window opens, so memory contents are left unchanged.
- R2: With sleep high and chip select high, the block is deselected and drive-enable is low.
- R3: With sleep high, chip select low, write enable high and output enable low, drive-enable is high and data-out carries the stored byte at the sampled address. The outputs follow the pins sampled on the previous rising clock edge.
- R4: With sleep high, chip select low, write enable high and output enable high, the block is in read standby and drive-enable is low.
- R5: With sleep high and chip select and write enable both low, the block is in write mode and drive-enable is low for either value of output enable.
- R6: A write window lasts while sleep is high and chip select and write enable are low. It may be closed by write enable rising, chip select rising or sleep falling. When it closes, the address and byte sampled on the last clock inside the window are committed.
- R7: While reading, a change of address yields the newly addressed byte one clock later.
- R8: A read of the address being committed in the same cycle returns the new byte.
- R9: Drive-enable is never high in a cycle in which the host reports that it drives data-in.
- R10: Reset forces drive-enable low and discards any open write window without committing it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rstN | input | 1 | Asynchronous reset, active low |
| sleepN | input | 1 | Sleep control, low puts the block to sleep |
| csN | input | 1 | Chip select, active low |
| weN | input | 1 | Write enable, active low |
| oeN | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Word address |
| dataIn | input | DATA_W | Host write data |
| hostDrives | input | 1 | High while the host drives data-in |
| dataOut | output | DATA_W | Read data, zero when not driving |
| driveEn | output | 1 | High when the block would drive the bus |

## Verification
The assertions assume that all pins are synchronous to the sampling clock. They also assume that the host, when moving from a read straight into a write, keeps its data driver off for one cycle. During that cycle the block's drive-enable, which is still high from the read, falls. The bench derives the host-drive flag the same way, from the drive state it expects in the previous cycle. It changes pins only on the falling clock edge. Random cycles draw the four controls with a bias toward selected operation, and addresses from a small pool plus the top word. This lets reads meet committed data often.

// File: rtl/sramPkg.sv
package sramPkg;
  typedef enum logic [2:0] {
    MODE_SLEEP,
    MODE_DESEL,
    MODE_READ,
    MODE_STBY,
    MODE_WRITE
  } sramMode_e;

  typedef struct packed {
    logic capture;
    logic commit;
    logic drive;
  } sramStrobe_t;
endpackage

// File: rtl/sramCtrl.sv
module sramCtrl
  import sramPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        sleepN,
  input  logic        csN,
  input  logic        weN,
  input  logic        oeN,
  output sramStrobe_t strobe
);
  logic slpQ, csQ, weQ, oeQ;
  logic winOpen, winPrev;
  sramMode_e mode;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      slpQ    <= 1'b1;
      csQ     <= 1'b1;
      weQ     <= 1'b1;
      oeQ     <= 1'b1;
      winPrev <= 1'b0;
    end else begin
      slpQ    <= sleepN;
      csQ     <= csN;
      weQ     <= weN;
      oeQ     <= oeN;
      winPrev <= winOpen;
    end
  end

  // Sleep outranks select, select outranks write, write outranks output enable.
  always_comb begin
    if (!slpQ)     mode = MODE_SLEEP;
    else if (csQ)  mode = MODE_DESEL;
    else if (!weQ) mode = MODE_WRITE;
    else if (oeQ)  mode = MODE_STBY;
    else           mode = MODE_READ;
  end

  assign winOpen        = (mode == MODE_WRITE);
  assign strobe.capture = winOpen;
  assign strobe.commit  = winPrev && !winOpen;
  assign strobe.drive   = (mode == MODE_READ);

  p_sleep_quiet_r1: assert property (@(posedge clk) disable iff (!rstN)
    !sleepN |=> !strobe.drive);
  p_desel_quiet_r2: assert property (@(posedge clk) disable iff (!rstN)
    (sleepN && csN) |=> !strobe.drive);
  p_read_drives_r3: assert property (@(posedge clk) disable iff (!rstN)
    (sleepN && !csN && weN && !oeN) |=> strobe.drive);
  p_standby_quiet_r4: assert property (@(posedge clk) disable iff (!rstN)
    (sleepN && !csN && weN && oeN) |=> !strobe.drive);
  p_write_quiet_r5: assert property (@(posedge clk) disable iff (!rstN)
    (sleepN && !csN && !weN) |=> !strobe.drive);
  p_close_commits_r6: assert property (@(posedge clk) disable iff (!rstN)
    (sleepN && !csN && !weN) |=> ##1 (strobe.capture || strobe.commit));
endmodule

// File: rtl/sramData.sv
module sramData
  import sramPkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  sramStrobe_t       strobe,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dataIn,
  input  logic              hostDrives,
  output logic [DATA_W-1:0] dataOut,
  output logic              driveEn
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] memArr [DEPTH];
  logic [ADDR_W-1:0] addrQ, pendAddr;
  logic [DATA_W-1:0] dinQ, pendData, readByte;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ    <= '0;
      dinQ     <= '0;
      pendAddr <= '0;
      pendData <= '0;
    end else begin
      addrQ <= addr;
      dinQ  <= dataIn;
      if (strobe.capture) begin
        pendAddr <= addrQ;
        pendData <= dinQ;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.commit) memArr[pendAddr] <= pendData;
  end

  // Forward the byte being committed so a read in the same cycle sees it.
  assign readByte = (strobe.commit && (pendAddr == addrQ)) ? pendData : memArr[addrQ];
  assign dataOut  = strobe.drive ? readByte : '0;
  assign driveEn  = strobe.drive;

  p_no_contention_r9: assert property (@(posedge clk) disable iff (!rstN)
    !(driveEn && hostDrives));
  p_idle_zero_r3: assert property (@(posedge clk) disable iff (!rstN)
    !driveEn |-> (dataOut == '0));
endmodule

// File: rtl/sramSleepModel.sv
module sramSleepModel
  import sramPkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sleepN,
  input  logic              csN,
  input  logic              weN,
  input  logic              oeN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dataIn,
  input  logic              hostDrives,
  output logic [DATA_W-1:0] dataOut,
  output logic              driveEn
);
  sramStrobe_t strobe;

  sramCtrl uCtrl (
    .clk    (clk),
    .rstN   (rstN),
    .sleepN (sleepN),
    .csN    (csN),
    .weN    (weN),
    .oeN    (oeN),
    .strobe (strobe)
  );

  sramData #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) uData (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .addr       (addr),
    .dataIn     (dataIn),
    .hostDrives (hostDrives),
    .dataOut    (dataOut),
    .driveEn    (driveEn)
  );
endmodule

// File: tb/tb_sramSleepModel.sv
`timescale 1ns/1ps
module tb_sramSleepModel;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sleepN = 1'b1, csN = 1'b1, weN = 1'b1, oeN = 1'b1, hostDrives = 1'b0;
  logic [7:0] addr = '0, dataIn = '0;
  logic [7:0] dataOut;
  logic driveEn;

  int vecCount = 0;
  int missCount = 0;
  bit finished = 0;

  logic [7:0] expMem [256];
  bit known [256];
  bit prevOpen = 0, prevDrive = 0;
  logic [7:0] pendA = '0, pendD = '0;

  always #2 clk = ~clk;

  sramSleepModel #(.ADDR_W(8), .DATA_W(8)) dut (
    .clk(clk), .rstN(rstN), .sleepN(sleepN), .csN(csN), .weN(weN), .oeN(oeN),
    .addr(addr), .dataIn(dataIn), .hostDrives(hostDrives),
    .dataOut(dataOut), .driveEn(driveEn)
  );

  function automatic string modeTag(bit s, bit c, bit w, bit o);
    if (!s) return "R1";
    if (c) return "R2";
    if (!w) return "R5";
    if (o) return "R4";
    return "R3";
  endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    vecCount++;
    if (!ok) begin
      missCount++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Drive one cycle of pins at a falling edge, check at the next falling edge.
  task automatic step(bit s, bit c, bit w, bit o, logic [7:0] a, logic [7:0] d, string tag);
    bit open, expDrive;
    open = s && !c && !w;
    sleepN = s; csN = c; weN = w; oeN = o; addr = a; dataIn = d;
    hostDrives = open && !prevDrive;
    @(posedge clk);
    @(negedge clk);
    if (prevOpen && !open) begin
      expMem[pendA] = pendD;
      known[pendA] = 1;
    end
    if (open) begin
      pendA = a;
      pendD = d;
    end
    prevOpen = open;
    expDrive = s && !c && w && !o;
    check(driveEn == expDrive, modeTag(s, c, w, o), int'(driveEn), int'(expDrive));
    if (expDrive && known[a])
      check(dataOut == expMem[a], tag, int'(dataOut), int'(expMem[a]));
    prevDrive = expDrive;
  endtask

  task automatic finishRun();
    $display("== %0d vectors applied, %0d miscompares ==", vecCount, missCount);
    $finish;
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      missCount++;
      $display("FAIL watchdog actual=hung expected=done");
      finishRun();
    end
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < 256; i++) known[i] = 0;
    repeat (3) @(negedge clk);
    check(driveEn == 1'b0, "R10", int'(driveEn), 0);
    rstN = 1'b1;
    @(negedge clk);
    check(driveEn == 1'b0, "R10", int'(driveEn), 0);

    // Write closed by write enable; same-cycle read takes the forwarded byte
    step(1,1,1,1, 8'd0, 8'h00, "R2");
    step(1,0,1,1, 8'd3, 8'h00, "R4");
    step(1,0,0,1, 8'd3, 8'h3C, "R6");
    step(1,0,0,1, 8'd3, 8'h3C, "R6");
    step(1,0,1,0, 8'd3, 8'h00, "R8");
    step(1,0,1,0, 8'd3, 8'h00, "R3");

    // Write closed by chip select, output enable low during the write
    step(1,1,0,1, 8'd7, 8'h00, "R2");
    step(1,0,0,0, 8'd7, 8'h71, "R5");
    step(1,1,0,0, 8'd7, 8'h00, "R6");
    step(1,0,1,0, 8'd7, 8'h00, "R6");

    // Write closed by sleep
    step(0,0,0,1, 8'd9, 8'h44, "R1");
    step(1,0,0,1, 8'd9, 8'h90, "R6");
    step(0,0,0,1, 8'd9, 8'h00, "R1");
    step(1,0,1,0, 8'd9, 8'h00, "R6");

    // Multi-cycle window: last sample wins
    step(1,0,0,1, 8'd10, 8'h11, "R6");
    step(1,0,0,1, 8'd11, 8'h22, "R6");
    step(1,0,0,1, 8'd12, 8'h33, "R6");
    step(1,0,1,0, 8'd12, 8'h00, "R6");

    // Sleep ignores write controls
    step(1,0,0,1, 8'd20, 8'h55, "R6");
    step(1,1,1,1, 8'd20, 8'h00, "R2");
    step(0,0,0,0, 8'd20, 8'hEE, "R1");
    step(0,0,0,0, 8'd20, 8'hEE, "R1");
    step(1,1,1,1, 8'd20, 8'h00, "R2");
    step(1,0,1,0, 8'd20, 8'h00, "R1");

    // Address changes during continuous read
    step(1,0,1,0, 8'd3,  8'h00, "R7");
    step(1,0,1,0, 8'd7,  8'h00, "R7");
    step(1,0,1,0, 8'd9,  8'h00, "R7");
    step(1,0,1,0, 8'd12, 8'h00, "R7");

    // Top address
    step(1,1,1,1, 8'd255, 8'h00, "R2");
    step(1,0,0,1, 8'd255, 8'hA5, "R6");
    step(1,0,1,0, 8'd255, 8'h00, "R8");

    // Reset during an open window discards it
    step(1,1,1,1, 8'd5, 8'h00, "R2");
    step(1,0,0,1, 8'd5, 8'h5A, "R6");
    step(1,0,0,1, 8'd5, 8'h5A, "R6");
    rstN = 1'b0; csN = 1'b1; weN = 1'b1; hostDrives = 1'b0;
    prevOpen = 0; prevDrive = 0;
    @(negedge clk);
    check(driveEn == 1'b0, "R10", int'(driveEn), 0);
    @(negedge clk);
    rstN = 1'b1;
    step(1,1,1,1, 8'd5, 8'h00, "R10");
    step(1,0,1,0, 8'd5, 8'h00, "R10");
    check(known[5] == 0, "R10", int'(known[5]), 0);
    check(dataOut != 8'h5A, "R10", int'(dataOut), 0);

    // Random traffic
    for (int n = 0; n < 3000; n++) begin
      bit s, c, w, o;
      logic [7:0] a;
      s = ($urandom % 8) != 0;
      c = ($urandom % 5) == 0;
      w = ($urandom % 2) != 0;
      o = ($urandom % 4) == 0;
      a = (($urandom % 16) == 0) ? 8'd255 : 8'($urandom % 16);
      step(s, c, w, o, a, 8'($urandom), "R3");
    end

    finished = 1;
    finishRun();
  end
endmodule